// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Programmer

This block sits on a simple register bus and burns one 32-bit word of a one-time-programmable fuse array at a time. Software loads a timing register, then writes the control register with the target word address and an arming key. A following write of the program data starts a sequence. The controller senses the present fuse word and removes any bits that are already blown. It then walks the remaining bits from least significant to most significant. Each set bit gets a relax interval, a program strobe and a second relax interval.

Locked words are refused: the controller never touches the array and raises a sticky error instead. After each programmed word a recovery gap, given in clock cycles, has to pass before the next fuse operation may begin. A separate request bit starts a fuse read cycle that reloads the shadow copies. The fuse array is outside the block and connects through a plain behavioural port.

Top module: `otp_word_prog`

## Requirements
- R1: Register offsets: control at 0x00 (word address in bits 6:0, busy in bit 8, error in bit 9, reload request in bit 10, arming key in bits 31:16, all other bits read 0), a write-1-to-set alias of control at 0x04, a write-1-to-clear alias at 0x08, timing at 0x10 (bits 21:0 kept) and data at 0x20. After reset every register reads 0 and neither fuse strobe is active.
- R2: A data write starts programming only if, before the write, the key field holds 0x3E77, error is clear, busy is clear and the recovery gap has expired. Any other data write only stores the value, and the fuse port stays quiet.
- R3: When programming starts, busy reads 1 and the key field reads 0 from the next cycle on.
- R4: The word address is captured at the start. While busy is set, writes to control, set, clear (except the error clear) and timing are dropped, so the programmed word and the control readback keep their values.
- R5: Programming first asserts fuse_rd for read-strobe+1 cycles (timing bits 21:16). Only bits that are 1 in the data and 0 in the sensed fuse word are strobed, one strobe per such bit.
- R6: Each strobe holds fuse_pgm for program-strobe+1 cycles (timing bits 11:0), with fuse_bit giving the bit index. Between two consecutive strobes, fuse_pgm is low for 2*(relax+1)+1 cycles (relax in timing bits 15:12).
- R7: The data register shifts right with zero fill once per bit step, so it reads 0 after programming. Data writes while busy is set are dropped.
- R8: A data write that meets the R2 conditions for a word flagged by fuse_locked sets error and clears the key. It never sets busy and causes no fuse access.
- R9: Error is sticky and blocks both programming and reload. It is cleared only by writing 1 to bit 9 through the clear alias; a direct write to control leaves it unchanged.
- R10: After busy falls at the end of programming, no new program or reload starts for GAP_CYCLES cycles.
- R11: Setting the reload bit while idle, error-free and past the gap sets busy and asserts fuse_rd for read-strobe+1 cycles. Busy and the reload bit then clear together.
- R12: The set alias ORs, and the clear alias removes, the written 1-bits of the address, reload and key fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and fuse clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| fuse_addr | output | 7 | Word address at the fuse array |
| fuse_bit | output | 5 | Bit index being programmed |
| fuse_rd | output | 1 | Fuse read strobe |
| fuse_pgm | output | 1 | Fuse program strobe |
| fuse_rdata | input | 32 | Sensed fuse word at fuse_addr |
| fuse_locked | input | 1 | Word at fuse_addr refuses programming |

## Verification
A write takes effect at the first clock edge it meets. Its register result, including busy, the key clear and error, can be read on the falling edge that follows, and the bench reads there. The fuse-side results arrive later and depend on the data: the read phase, then per-bit relax and strobe phases, whose lengths follow from the timing fields. The bench therefore polls busy with a bounded loop and only then compares the fuse model contents. It measures strobe widths and the low gap between strobes with edge-by-edge run counters, not fixed delays. The recovery gap is checked on both sides: one attempt within a few cycles of completion must not start, and one made well after GAP_CYCLES must start.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    localparam int DATA_W   = 32;
    localparam int WADDR_W  = 7;
    localparam int BITCNT_W = $clog2(DATA_W) + 1;
    localparam int PHASE_W  = 12;
    localparam int TIME_W   = 22;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_SET  = 8'h04;
    localparam logic [7:0] OFS_CLR  = 8'h08;
    localparam logic [7:0] OFS_TIME = 8'h10;
    localparam logic [7:0] OFS_DATA = 8'h20;

    localparam logic [15:0] ARM_KEY = 16'h3E77;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_SCAN,
        PH_PRE,
        PH_STROBE,
        PH_POST,
        PH_RELOAD
    } phase_e;

    typedef struct packed {
        logic [15:0]        key;
        logic               reload;
        logic               err;
        logic               busy;
        logic [WADDR_W-1:0] addr;
    } ctrl_t;

    typedef struct packed {
        phase_e              ph;
        ctrl_t               ctrl;
        logic [WADDR_W-1:0]  lat_addr;
        logic [TIME_W-1:0]   timing;
        logic [DATA_W-1:0]   data;
        logic [BITCNT_W-1:0] bit_cnt;
    } prog_state_t;

endpackage

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_recovery_timer.sv
module otp_recovery_timer #(
    parameter int GAP_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = GW'(GAP_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/otp_word_prog.sv
module otp_word_prog
    import otp_prog_pkg::*;
#(
    parameter int GAP_CYCLES = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [6:0]  fuse_addr,
    output logic [4:0]  fuse_bit,
    output logic        fuse_rd,
    output logic        fuse_pgm,
    input  logic [31:0] fuse_rdata,
    input  logic        fuse_locked
);
    prog_state_t s_d, s_q;

    logic               ph_load;
    logic [PHASE_W-1:0] ph_val;
    logic               ph_done;
    logic               gap_go;
    logic               gap_ready;
    logic               ctrl_acc;
    logic               prog_go;

    logic               busy_w;
    logic               err_w;
    logic [15:0]        key_w;
    logic               gap_ready_w;

    otp_phase_timer #(.CNT_W(PHASE_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_done)
    );

    otp_recovery_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (gap_go),
        .ready (gap_ready)
    );

    always_comb begin
        s_d      = s_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        gap_go   = 1'b0;
        prog_go  = 1'b0;
        ctrl_acc = reg_we && !s_q.ctrl.busy;

        // error clear is honoured in every phase
        if (reg_we && reg_addr == OFS_CLR && reg_wdata[9])
            s_d.ctrl.err = 1'b0;

        if (ctrl_acc) begin
            case (reg_addr)
                OFS_CTRL: begin
                    s_d.ctrl.addr   = reg_wdata[WADDR_W-1:0];
                    s_d.ctrl.reload = reg_wdata[10];
                    s_d.ctrl.key    = reg_wdata[31:16];
                end
                OFS_SET: begin
                    s_d.ctrl.addr   = s_q.ctrl.addr | reg_wdata[WADDR_W-1:0];
                    s_d.ctrl.reload = s_q.ctrl.reload | reg_wdata[10];
                    s_d.ctrl.key    = s_q.ctrl.key | reg_wdata[31:16];
                end
                OFS_CLR: begin
                    s_d.ctrl.addr   = s_q.ctrl.addr & ~reg_wdata[WADDR_W-1:0];
                    s_d.ctrl.reload = s_q.ctrl.reload & ~reg_wdata[10];
                    s_d.ctrl.key    = s_q.ctrl.key & ~reg_wdata[31:16];
                end
                OFS_TIME: s_d.timing = reg_wdata[TIME_W-1:0];
                OFS_DATA: begin
                    s_d.data = reg_wdata;
                    if (s_q.ctrl.key == ARM_KEY && !s_q.ctrl.err && gap_ready) begin
                        s_d.ctrl.key = '0;
                        if (fuse_locked) begin
                            s_d.ctrl.err = 1'b1;
                        end else begin
                            prog_go        = 1'b1;
                            s_d.ctrl.busy  = 1'b1;
                            s_d.lat_addr   = s_q.ctrl.addr;
                            s_d.ph         = PH_READ;
                            ph_load        = 1'b1;
                            ph_val         = PHASE_W'(s_q.timing[21:16]);
                        end
                    end
                end
                default: ;
            endcase
        end

        case (s_q.ph)
            PH_IDLE: begin
                if (!reg_we && !prog_go && s_q.ctrl.reload && !s_q.ctrl.err && gap_ready) begin
                    s_d.ctrl.busy = 1'b1;
                    s_d.ph        = PH_RELOAD;
                    ph_load       = 1'b1;
                    ph_val        = PHASE_W'(s_q.timing[21:16]);
                end
            end
            PH_READ: begin
                if (ph_done) begin
                    s_d.data    = s_q.data & ~fuse_rdata;
                    s_d.bit_cnt = '0;
                    s_d.ph      = PH_SCAN;
                end
            end
            PH_SCAN: begin
                if (s_q.bit_cnt == BITCNT_W'(DATA_W)) begin
                    s_d.ctrl.busy = 1'b0;
                    s_d.ph        = PH_IDLE;
                    gap_go        = 1'b1;
                end else if (s_q.data[0]) begin
                    s_d.ph  = PH_PRE;
                    ph_load = 1'b1;
                    ph_val  = PHASE_W'(s_q.timing[15:12]);
                end else begin
                    s_d.data    = {1'b0, s_q.data[DATA_W-1:1]};
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                end
            end
            PH_PRE: begin
                if (ph_done) begin
                    s_d.ph  = PH_STROBE;
                    ph_load = 1'b1;
                    ph_val  = s_q.timing[11:0];
                end
            end
            PH_STROBE: begin
                if (ph_done) begin
                    s_d.ph  = PH_POST;
                    ph_load = 1'b1;
                    ph_val  = PHASE_W'(s_q.timing[15:12]);
                end
            end
            PH_POST: begin
                if (ph_done) begin
                    s_d.data    = {1'b0, s_q.data[DATA_W-1:1]};
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                    s_d.ph      = PH_SCAN;
                end
            end
            PH_RELOAD: begin
                if (ph_done) begin
                    s_d.ctrl.busy   = 1'b0;
                    s_d.ctrl.reload = 1'b0;
                    s_d.ph          = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL, OFS_SET, OFS_CLR:
                reg_rdata = {s_q.ctrl.key, 5'b0, s_q.ctrl.reload, s_q.ctrl.err,
                             s_q.ctrl.busy, 1'b0, s_q.ctrl.addr};
            OFS_TIME: reg_rdata = {{(DATA_W-TIME_W){1'b0}}, s_q.timing};
            OFS_DATA: reg_rdata = s_q.data;
            default:  reg_rdata = '0;
        endcase
    end

    assign fuse_addr   = s_q.ctrl.busy ? s_q.lat_addr : s_q.ctrl.addr;
    assign fuse_bit    = s_q.bit_cnt[4:0];
    assign fuse_rd     = (s_q.ph == PH_READ) || (s_q.ph == PH_RELOAD);
    assign fuse_pgm    = (s_q.ph == PH_STROBE);

    assign busy_w      = s_q.ctrl.busy;
    assign err_w       = s_q.ctrl.err;
    assign key_w       = s_q.ctrl.key;
    assign gap_ready_w = gap_ready;
endmodule

// File: rtl/otp_word_prog_chk.sv
module otp_word_prog_chk
    import otp_prog_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        fuse_rd,
    input logic        fuse_pgm,
    input logic        fuse_locked,
    input logic        busy,
    input logic        err,
    input logic [15:0] key,
    input logic        gap_ready
);
    logic try_prog;
    assign try_prog = reg_we && reg_addr == OFS_DATA && !busy && key == ARM_KEY
                      && !err && gap_ready;

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        try_prog && !fuse_locked |=> busy && key == 16'h0);

    p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        try_prog && fuse_locked |=> err && !busy && !fuse_rd && !fuse_pgm);

    p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err && !(reg_we && reg_addr == OFS_CLR && reg_wdata[9]) |=> err);

    p_gap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_ready && !busy |=> !busy);

    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_pgm |-> busy && key == 16'h0);

    p_rd_pgm_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_rd && fuse_pgm));
endmodule

bind otp_word_prog otp_word_prog_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .fuse_rd     (fuse_rd),
    .fuse_pgm    (fuse_pgm),
    .fuse_locked (fuse_locked),
    .busy        (busy_w),
    .err         (err_w),
    .key         (key_w),
    .gap_ready   (gap_ready_w)
);

// File: tb/otp_word_prog_bench.sv
`timescale 1ns/1ps
module otp_word_prog_bench;
    localparam int GAP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [6:0]  fuse_addr;
    logic [4:0]  fuse_bit;
    logic        fuse_rd, fuse_pgm;
    logic [31:0] fuse_rdata;
    logic        fuse_locked;

    int checks = 0;
    int fails  = 0;

    logic [31:0] fmem [0:127];
    logic        pgm_prev, rd_prev, seen_strobe;
    int          n_strobe, n_rd, pgm_run, rd_run, lo_run;
    int          last_pgm_w, last_rd_w, min_gap;

    always #2 clk = ~clk;

    otp_word_prog #(.GAP_CYCLES(GAP)) u_otp_word_prog (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_addr(fuse_addr),
        .fuse_bit(fuse_bit), .fuse_rd(fuse_rd), .fuse_pgm(fuse_pgm),
        .fuse_rdata(fuse_rdata), .fuse_locked(fuse_locked)
    );

    assign fuse_rdata  = fmem[fuse_addr];
    assign fuse_locked = (fuse_addr == 7'd5);

    // behavioural fuse array and strobe monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) fmem[i] <= 32'h0;
            fmem[2] <= 32'h0000_00F0;
            pgm_prev <= 1'b0; rd_prev <= 1'b0; seen_strobe <= 1'b0;
            n_strobe <= 0; n_rd <= 0; pgm_run <= 0; rd_run <= 0; lo_run <= 0;
            last_pgm_w <= 0; last_rd_w <= 0; min_gap <= 9999;
        end else begin
            pgm_prev <= fuse_pgm;
            rd_prev  <= fuse_rd;
            if (fuse_pgm && !pgm_prev) begin
                fmem[fuse_addr][fuse_bit] <= 1'b1;
                n_strobe <= n_strobe + 1;
                seen_strobe <= 1'b1;
                if (seen_strobe && lo_run < min_gap) min_gap <= lo_run;
            end
            if (fuse_pgm) begin
                pgm_run <= pgm_run + 1;
                lo_run  <= 0;
            end else begin
                if (pgm_prev) last_pgm_w <= pgm_run;
                pgm_run <= 0;
                lo_run  <= lo_run + 1;
            end
            if (fuse_rd) begin
                rd_run <= rd_run + 1;
                if (!rd_prev) n_rd <= n_rd + 1;
            end else begin
                if (rd_prev) last_rd_w <= rd_run;
                rd_run <= 0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        bit done = 0;
        for (int i = 0; i < 3000 && !done; i++) begin
            rd(8'h00, v);
            if (!v[8]) done = 1;
        end
        check("R2 busy ends", {31'b0, done}, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 ctrl reset", v, 32'h0);
        rd(8'h10, v); check("R1 timing reset", v, 32'h0);
        rd(8'h20, v); check("R1 data reset", v, 32'h0);
        check("R1 strobes idle", {30'b0, fuse_rd, fuse_pgm}, 32'h0);
        wr(8'h10, 32'hFFC2_1003);
        rd(8'h10, v); check("R1 timing keeps bits 21:0", v, 32'h0002_1003);
    endtask

    task automatic t_no_key();
        logic [31:0] v;
        int s0 = n_strobe, r0 = n_rd;
        wr(8'h00, 32'h0000_0003);
        wr(8'h20, 32'h0000_000F);
        repeat (10) @(negedge clk);
        rd(8'h00, v); check("R2 no key no busy", v, 32'h0000_0003);
        rd(8'h20, v); check("R2 data stored", v, 32'h0000_000F);
        check("R2 fuse untouched", fmem[3], 32'h0);
        check("R2 no fuse access", n_strobe - s0 + n_rd - r0, 32'h0);
    endtask

    task automatic t_program();
        logic [31:0] v;
        int s0 = n_strobe;
        wr(8'h00, 32'h3E77_0002);
        wr(8'h20, 32'h0000_0F3C);
        rd(8'h00, v); check("R3 busy set key cleared", v, 32'h0000_0102);
        wr(8'h00, 32'h3E77_0009);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R4 ctrl write ignored while busy", v, 32'h0000_0102);
        wait_idle();
        check("R5 masked result", fmem[2], 32'h0000_0FFC);
        check("R5 strobe count", n_strobe - s0, 32'd6);
        check("R5 read strobe width", last_rd_w, 32'd3);
        check("R6 program strobe width", last_pgm_w, 32'd4);
        check("R6 gap between strobes", min_gap, 32'd5);
        check("R4 other word untouched", fmem[9], 32'h0);
        rd(8'h20, v); check("R7 data shifted to zero", v, 32'h0);
    endtask

    task automatic t_gap();
        logic [31:0] v;
        wr(8'h00, 32'h3E77_0004);
        wr(8'h20, 32'h0000_0001);
        repeat (5) @(negedge clk);
        rd(8'h00, v); check("R10 start held off", v, 32'h3E77_0004);
        check("R10 fuse untouched in gap", fmem[4], 32'h0);
        repeat (GAP + 10) @(negedge clk);
        wr(8'h20, 32'h0000_0001);
        rd(8'h00, v); check("R10 start after gap", v[8], 1'b1);
        wait_idle();
        check("R10 word programmed", fmem[4], 32'h1);
        repeat (GAP + 10) @(negedge clk);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        bit saw_busy = 0;
        int r0 = n_rd, s0 = n_strobe;
        wr(8'h00, 32'h3E77_0005);
        wr(8'h20, 32'h0000_00FF);
        for (int i = 0; i < 10; i++) begin
            rd(8'h00, v);
            if (v[8]) saw_busy = 1;
        end
        check("R8 busy never set", {31'b0, saw_busy}, 32'h0);
        check("R8 error set key cleared", v, 32'h0000_0205);
        check("R8 no fuse access", n_rd - r0 + n_strobe - s0, 32'h0);
        check("R8 fuse unchanged", fmem[5], 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        wr(8'h00, 32'h3E77_0006);
        wr(8'h20, 32'h0000_0001);
        repeat (5) @(negedge clk);
        rd(8'h00, v); check("R9 error blocks program", v, 32'h3E77_0206);
        check("R9 fuse unchanged", fmem[6], 32'h0);
        wr(8'h04, 32'h0000_0400);
        repeat (5) @(negedge clk);
        rd(8'h00, v); check("R9 error blocks reload", v, 32'h3E77_0606);
        wr(8'h08, 32'h0000_0400);
        wr(8'h00, 32'h3E77_0006);
        rd(8'h00, v); check("R9 direct write keeps error", v, 32'h3E77_0206);
        wr(8'h08, 32'h0000_0200);
        rd(8'h00, v); check("R9 clear alias drops error", v, 32'h3E77_0006);
        wr(8'h20, 32'h0000_0001);
        wait_idle();
        check("R9 program after clear", fmem[6], 32'h1);
        repeat (GAP + 10) @(negedge clk);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        int r0 = n_rd;
        wr(8'h04, 32'h0000_0400);
        rd(8'h00, v); check("R11 reload busy", v[10:8], 3'b101);
        wait_idle();
        rd(8'h00, v); check("R11 reload bit cleared", v, 32'h0000_0006);
        check("R11 read strobe width", last_rd_w, 32'd3);
        check("R11 one read", n_rd - r0, 32'd1);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'h00, 32'h0000_0011);
        wr(8'h04, 32'h0001_0022);
        rd(8'h00, v); check("R12 set alias ORs", v, 32'h0001_0033);
        wr(8'h08, 32'h0001_0001);
        rd(8'h08, v); check("R12 clear alias removes", v, 32'h0000_0032);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_key();
        t_program();
        t_gap();
        t_locked();
        t_error();
        t_reload();
        t_alias();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule